// File: doc/BRIEF.md
# Dense 24-bit Vector Pack/Unpack Unit

This unit converts between wide registers that hold eight 32-bit lanes and a compact layout in which only the low 24 bits of each lane are kept, packed back to back. Software uses the compact layout to hold vectors of small values in memory with no wasted bytes. The unit reads two 256-bit sources, a direction select, a 2-bit coarse shift code and a valid strobe. One cycle later it returns a registered 256-bit result together with a valid flag.

In pack direction, each source is reduced to a 192-bit dense string, with lane 0 at the bottom. The two strings are joined with the first source on top. A 64-bit zero pad goes on each end, which gives a 512-bit value. That value is shifted right by the shift code times 64, and the low 256 bits form the result. Because of this layout, three packs can lay four vectors end to end across 768 bits. In unpack direction, the two sources are joined into 512 bits (first source on top) and shifted the same way. The low 192 bits are then split into eight 24-bit elements, and each element is zero-extended into its own 32-bit lane.

A two-state controller drives the output flag. The state IDLE means no fresh result, and PRESENT means a result was captured on the last edge. The transition IDLE→PRESENT and PRESENT→PRESENT is taken when in_valid_i is high. The transition PRESENT→IDLE and IDLE→IDLE is taken when it is low. Reset forces IDLE.

Top module: `vpk_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid_o is 0 and result_o is all zeros.
- R2: out_valid_o is 1 in exactly the cycle after a cycle with in_valid_i high, and 0 otherwise (states PRESENT and IDLE).
- R3: result_o changes only on a clock edge where in_valid_i is high. Inputs presented with in_valid_i low have no effect on it.
- R4: In pack direction, bits [31:24] of every source lane are ignored. Bits [23:0] of lane i occupy bits [24i+23:24i] of that source's 192-bit dense string.
- R5: In pack direction the result is bits [255:0] of ({64'b0, dense(src_hi_i), dense(src_lo_i), 64'b0} >> 64*shamt_i). With shamt_i = 0, result bits [63:0] are zero.
- R6: pack_sel_i = 1 selects pack and pack_sel_i = 0 selects unpack.
- R7: In unpack direction, let w = {src_hi_i, src_lo_i} >> 64*shamt_i. Then lane i of the result is {8'h00, w[24i+23:24i]}, so bits [31:24] of every lane are zero.
- R8: shamt_i codes 0, 1, 2 and 3 select right shifts of 0, 64, 128 and 192 bits, in both directions.
- R9: Take four vectors v0..v3. Packing the pairs (v1,v0,1), (v2,v1,2) and (v3,v2,3) gives p0, p1, p2. Unpacking (p1,p0,0), (p1,p0,3), (p2,p1,2) and (p2,p2,1) then returns the low 24 bits of every lane of v0, v1, v2 and v3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operands valid this cycle |
| pack_sel_i | input | 1 | 1 = pack, 0 = unpack |
| shamt_i | input | 2 | Coarse shift code, times 64 bits |
| src_hi_i | input | 256 | First source, upper half of the joined value |
| src_lo_i | input | 256 | Second source, lower half of the joined value |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 256 | Registered result |

## Verification
Each part of the datapath leaves its own mark on the result, seen on result_o one cycle after the strobe. A wrong lane mapping in the dense stage moves 24-bit fields. A wrong pad or window index moves whole 64-bit blocks. A missing zero extension leaves non-zero upper bytes in the unpacked lanes. A controller stuck in either state shows on out_valid_o on the very next edge. A result register that loads without a strobe shows as a change on result_o in a cycle where in_valid_i was low. The round-trip sequence catches any mismatch between how pack places data and how unpack fetches it.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } vpk_state_e;

    typedef enum logic {
        DIR_UNPACK = 1'b0,
        DIR_PACK   = 1'b1
    } vpk_dir_e;

endpackage

// File: rtl/vpk_densify.sv
module vpk_densify #(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int ELEM_W = 24
) (
    input  logic [LANES*LANE_W-1:0] lanes_i,
    output logic [LANES*ELEM_W-1:0] dense_o
);
    localparam int DROP_W = LANE_W - ELEM_W;

    logic [LANES*DROP_W-1:0] unused_tops;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dense_o[g*ELEM_W +: ELEM_W]     = lanes_i[g*LANE_W +: ELEM_W];
        assign unused_tops[g*DROP_W +: DROP_W] = lanes_i[g*LANE_W+ELEM_W +: DROP_W];
    end

    logic unused_fold;
    assign unused_fold = ^unused_tops;
endmodule

// File: rtl/vpk_expand.sv
module vpk_expand #(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int ELEM_W = 24
) (
    input  logic [LANES*ELEM_W-1:0] dense_i,
    output logic [LANES*LANE_W-1:0] lanes_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_o[g*LANE_W +: LANE_W] = LANE_W'(dense_i[g*ELEM_W +: ELEM_W]);
    end
endmodule

// File: rtl/vpk_window.sv
module vpk_window #(
    parameter int IN_W  = 512,
    parameter int OUT_W = 256,
    parameter int STEP  = 64,
    parameter int SEL_W = 2
) (
    input  logic [IN_W-1:0]  wide_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [OUT_W-1:0] win_o
);
    localparam int STEPS = 2 ** SEL_W;
    localparam int NEED  = OUT_W + (STEPS - 1) * STEP;
    localparam int EXT_W = (NEED > IN_W) ? NEED : IN_W;

    logic [EXT_W-1:0] ext;
    logic [OUT_W-1:0] slice [STEPS];

    assign ext = EXT_W'(wide_i);

    for (genvar k = 0; k < STEPS; k++) begin : g_slice
        assign slice[k] = ext[k*STEP +: OUT_W];
    end

    if (EXT_W > NEED) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^ext[EXT_W-1:NEED];
    end

    assign win_o = slice[sel_i];
endmodule

// File: rtl/vpk_unit.sv
module vpk_unit #(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int ELEM_W = 24,
    parameter int STEP   = 64,
    parameter int SH_W   = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     in_valid_i,
    input  logic                     pack_sel_i,
    input  logic [SH_W-1:0]          shamt_i,
    input  logic [LANES*LANE_W-1:0]  src_hi_i,
    input  logic [LANES*LANE_W-1:0]  src_lo_i,
    output logic                     out_valid_o,
    output logic [LANES*LANE_W-1:0]  result_o
);
    import vpk_pkg::*;

    localparam int REG_W   = LANES * LANE_W;
    localparam int DENSE_W = LANES * ELEM_W;
    localparam int WIDE_W  = 2 * REG_W;
    localparam int PAD_W   = (WIDE_W - 2 * DENSE_W) / 2;

    function automatic logic [REG_W-1:0] build_top_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int b = ELEM_W; b < LANE_W; b++) begin
                m[i*LANE_W + b] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] TOP_MASK = build_top_mask();

    // dense strings of both sources
    logic [DENSE_W-1:0] dense_hi, dense_lo;

    vpk_densify #(.LANES(LANES), .LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_dense_hi (
        .lanes_i (src_hi_i),
        .dense_o (dense_hi)
    );

    vpk_densify #(.LANES(LANES), .LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_dense_lo (
        .lanes_i (src_lo_i),
        .dense_o (dense_lo)
    );

    // one shared window selector serves both directions
    logic [WIDE_W-1:0] packed_wide, pair_wide, wide_sel;
    logic [REG_W-1:0]  win, unpacked, next_result;
    vpk_dir_e          dir;

    assign dir         = vpk_dir_e'(pack_sel_i);
    assign packed_wide = {{PAD_W{1'b0}}, dense_hi, dense_lo, {PAD_W{1'b0}}};
    assign pair_wide   = {src_hi_i, src_lo_i};
    assign wide_sel    = (dir == DIR_PACK) ? packed_wide : pair_wide;

    vpk_window #(.IN_W(WIDE_W), .OUT_W(REG_W), .STEP(STEP), .SEL_W(SH_W)) u_window (
        .wide_i (wide_sel),
        .sel_i  (shamt_i),
        .win_o  (win)
    );

    logic unused_win_top;
    assign unused_win_top = ^win[REG_W-1:DENSE_W] & (dir == DIR_UNPACK);

    vpk_expand #(.LANES(LANES), .LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_expand (
        .dense_i (win[DENSE_W-1:0]),
        .lanes_o (unpacked)
    );

    assign next_result = (dir == DIR_PACK) ? win : unpacked;

    // controller
    vpk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = in_valid_i ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = in_valid_i ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)         result_o <= '0;
        else if (in_valid_i) result_o <= next_result;
    end

    assign out_valid_o = (state_q == ST_PRESENT);

    // checks next to the logic they guard
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_valid_o && result_o == '0));

    assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    assert_valid_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(result_o));

    assert_pack_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && pack_sel_i && shamt_i == '0) |=> (result_o[PAD_W-1:0] == '0));

    assert_unpack_zext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !pack_sel_i) |=> ((result_o & TOP_MASK) == '0));
endmodule

// File: tb/vpk_unit_bench.sv
module vpk_unit_bench;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         pack_sel = 1'b0;
    logic [1:0]   shamt = 2'd0;
    logic [W-1:0] src_hi = '0;
    logic [W-1:0] src_lo = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    vpk_unit u_vpk_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .pack_sel_i  (pack_sel),
        .shamt_i     (shamt),
        .src_hi_i    (src_hi),
        .src_lo_i    (src_lo),
        .out_valid_o (out_valid),
        .result_o    (result)
    );

    function automatic logic [W-1:0] pack_model(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                                 input logic [1:0] sh);
        logic [2*W-1:0] wide;
        logic [2*W-1:0] moved;
        wide = '0;
        for (int i = 0; i < 8; i++) begin
            wide[64 + 24*i +: 24]  = lo[32*i +: 24];
            wide[256 + 24*i +: 24] = hi[32*i +: 24];
        end
        moved = wide >> (64 * int'(sh));
        return moved[W-1:0];
    endfunction

    function automatic logic [W-1:0] unpack_model(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                                   input logic [1:0] sh);
        logic [2*W-1:0] wide;
        logic [W-1:0]   r;
        wide = {hi, lo} >> (64 * int'(sh));
        r = '0;
        for (int i = 0; i < 8; i++) begin
            r[32*i +: 32] = {8'h00, wide[24*i +: 24]};
        end
        return r;
    endfunction

    function automatic logic [W-1:0] pattern(input int seed);
        logic [W-1:0] v;
        for (int i = 0; i < 8; i++) begin
            v[32*i +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(i) * 32'h01010101 + 32'(seed) * 32'h00C0FFEE);
        end
        return v;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one operation, sample one cycle later away from the edge
    task automatic run_op(input logic sel, input logic [1:0] sh,
                          input logic [W-1:0] hi, input logic [W-1:0] lo,
                          output logic [W-1:0] got);
        @(negedge clk);
        in_valid = 1'b1;
        pack_sel = sel;
        shamt    = sh;
        src_hi   = hi;
        src_lo   = lo;
        @(negedge clk);
        in_valid = 1'b0;
        got = result;
        check_bit("R2 valid after strobe", out_valid, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        logic [W-1:0] v [4];
        logic [W-1:0] p [3];
        logic [W-1:0] held;

        // R1 reset state
        repeat (3) @(negedge clk);
        check_bit("R1 valid in reset", out_valid, 1'b0);
        check_vec("R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 valid after reset", out_valid, 1'b0);
        check_vec("R1 result after reset", result, '0);

        // R5 R6 R7 R8 sweep over direction, shift code and patterns
        for (int s = 1; s <= 6; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [W-1:0] a, b;
                    a = pattern(s);
                    b = pattern(s + 17);
                    if (s == 5) a = '1;
                    if (s == 6) b = '0;
                    run_op(m[0], k[1:0], a, b, got);
                    if (m == 1)
                        check_vec("R5 R6 R8 pack sweep", got, pack_model(a, b, k[1:0]));
                    else
                        check_vec("R7 R6 R8 unpack sweep", got, unpack_model(a, b, k[1:0]));
                end
            end
        end

        // R4 upper bytes ignored in pack
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] a, b;
            a = pattern(40 + k);
            b = pattern(50 + k);
            for (int i = 0; i < 8; i++) begin
                a[32*i+24 +: 8] = 8'hFF;
                b[32*i+24 +: 8] = 8'hA5;
            end
            run_op(1'b1, k[1:0], a, b, got);
            for (int i = 0; i < 8; i++) begin
                a[32*i+24 +: 8] = 8'h00;
                b[32*i+24 +: 8] = 8'h00;
            end
            check_vec("R4 pack ignores lane tops", got, pack_model(a, b, k[1:0]));
        end

        // R2 flag drops when no strobe; R3 result held while inputs change
        held = got;
        @(negedge clk);
        pack_sel = 1'b0;
        shamt    = 2'd2;
        src_hi   = pattern(99);
        src_lo   = pattern(98);
        @(negedge clk);
        check_bit("R2 valid low without strobe", out_valid, 1'b0);
        check_vec("R3 result held without strobe", result, held);
        @(negedge clk);
        check_vec("R3 result still held", result, held);

        // R9 round trip of four vectors
        for (int i = 0; i < 4; i++) v[i] = pattern(70 + i);
        run_op(1'b1, 2'd1, v[1], v[0], p[0]);
        run_op(1'b1, 2'd2, v[2], v[1], p[1]);
        run_op(1'b1, 2'd3, v[3], v[2], p[2]);
        run_op(1'b0, 2'd0, p[1], p[0], got);
        check_vec("R9 round trip v0", got, v[0] & {8{32'h00FFFFFF}});
        run_op(1'b0, 2'd3, p[1], p[0], got);
        check_vec("R9 round trip v1", got, v[1] & {8{32'h00FFFFFF}});
        run_op(1'b0, 2'd2, p[2], p[1], got);
        check_vec("R9 round trip v2", got, v[2] & {8{32'h00FFFFFF}});
        run_op(1'b0, 2'd1, p[2], p[2], got);
        check_vec("R9 round trip v3", got, v[3] & {8{32'h00FFFFFF}});

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule